// File: doc/BRIEF.md
# Interrupt Pending State Bank

This block keeps the pending state for a bank of interrupt inputs ahead of priority arbitration. For every interrupt it holds a latched pending bit and a registered copy of the input line. Each input is configured as edge-sensitive or level-sensitive. The pending vector it outputs combines the two: an edge-sensitive interrupt is pending only while its latch is set. A level-sensitive interrupt is pending while its latch is set or its line is high.

Software can set or clear pending bits through mask-qualified strobes. Software can also complete an interrupt by acknowledging its ID. The lowest interrupt IDs are reserved for software-generated interrupts. These are fixed as edge-sensitive. The set and clear paths cannot touch them, so they become pending only through their own lines.

Enable gating is not applied here. An interrupt goes pending whether or not it will later be enabled for delivery.

Top module: `irq_pending_bank`

## Requirements
- R1: A level-sensitive interrupt reads pending in the cycle after its line is sampled high, whether or not its latch is set. Pending is the latch OR the registered line level.
- R2: An edge-sensitive interrupt reads pending only from its latch. After an acknowledge, a line that stays high does not make it pending again.
- R3: A rising line (high now, low at the previous sample) sets the latch only when the interrupt is edge-sensitive. A level-sensitive interrupt whose line rose and then fell is no longer pending.
- R4: A clear-pending strobe on a level-sensitive interrupt whose line is still high leaves it pending.
- R5: A level-sensitive interrupt set pending by software stays pending after its line falls. It stays pending until a clear-pending strobe or an acknowledge of its ID.
- R6: Configuration is written one byte at a time.
  - Byte k covers IDs 4k to 4k+3.
  - Bit 2j+1 of the byte selects the mode of ID 4k+j: 1 means edge, 0 means level.
  - The even bits are ignored.
  - IDs below NUM_SGI always read as edge on `cfg_edge`, and writes to them are ignored.
- R7: Set-pending and clear-pending masks have no effect on IDs below NUM_SGI.
- R8: An acknowledge clears the latch of the addressed ID, and the clear is visible in the next cycle. A rising edge on an edge-sensitive line in the same cycle wins, and the interrupt stays pending.
- R9: When set-pending and clear-pending both hit the same ID in one cycle, set wins.
- R10: After reset nothing is pending, all line samples are low, and IDs from NUM_SGI upward are level-sensitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_line | input | NUM_IRQ | Interrupt lines, one per ID |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_idx | input | CFG_IDX_W | Configuration byte index (IDs 4k..4k+3) |
| cfg_wr_data | input | 8 | Configuration byte; odd bits select edge mode |
| set_en | input | 1 | Set-pending strobe |
| set_mask | input | NUM_IRQ | IDs to set pending |
| clr_en | input | 1 | Clear-pending strobe |
| clr_mask | input | NUM_IRQ | IDs to clear pending |
| ack_en | input | 1 | Acknowledge strobe |
| ack_id | input | ID_W | Acknowledged interrupt ID |
| cfg_edge | output | NUM_IRQ | Current mode per ID, 1 = edge |
| pending | output | NUM_IRQ | Pending vector |

## Verification
An acknowledge can land in the same cycle as a fresh rising edge on the same edge-sensitive line. The bench provokes this by setting the interrupt pending and then driving the acknowledge and the line rise together on one clock. It judges the result correct only if the interrupt still reads pending afterwards; a second, lone acknowledge must then clear it. A second collision, set-pending and clear-pending hitting the same ID in one cycle, is driven the same way and must leave the ID pending.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
   typedef enum logic {TRIG_LEVEL = 1'b0, TRIG_EDGE = 1'b1} trig_e;

   // bit in a configuration byte that selects the mode of slot j
   function automatic int mode_bit(input int slot);
      return 2 * slot + 1;
   endfunction

   function automatic int min1_clog2(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/irqp_cfg.sv
module irqp_cfg
   import irqp_pkg::*;
#(
   parameter int NUM_IRQ = 32,
   parameter int NUM_SGI = 16,
   parameter int IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [7:0]         wr_data,
   output logic [NUM_IRQ-1:0] edge_o
);
   logic unused_even;
   assign unused_even = ^{wr_data[6], wr_data[4], wr_data[2], wr_data[0]};

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mode
      if (i < NUM_SGI) begin : g_fixed
         assign edge_o[i] = TRIG_EDGE;
      end else begin : g_reg
         logic mode_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mode_q <= TRIG_LEVEL;
            else if (wr_en && wr_idx == IDX_W'(i / 4))
               mode_q <= wr_data[mode_bit(i % 4)];
         end
         assign edge_o[i] = mode_q;
      end
   end

   // R6: a write to a byte of software-generated IDs changes no mode
   p_sgi_cfg_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_idx) * 4 + 3 < NUM_SGI)) |=> $stable(edge_o));
endmodule

// File: rtl/irqp_cell.sv
module irqp_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic line,
   input  logic edge_mode,
   input  logic set_hit,
   input  logic clr_hit,
   input  logic ack_hit,
   output logic pend
);
   logic lvl_q, lat_q, lat_d, rise;

   assign rise = line & ~lvl_q;

   always_comb begin
      lat_d = lat_q;
      if (ack_hit)            lat_d = 1'b0;
      if (clr_hit)            lat_d = 1'b0;
      if (set_hit)            lat_d = 1'b1;
      if (edge_mode && rise)  lat_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         lat_q <= 1'b0;
      end else begin
         lvl_q <= line;
         lat_q <= lat_d;
      end
   end

   assign pend = lat_q | (~edge_mode & lvl_q);

   // R1: a high level line shows as pending next cycle
   p_level_pend_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_mode && line) |=> (pend || edge_mode));
   // R3: a rising edge on an edge-sensitive line latches pending
   p_edge_latch_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && line && !lvl_q) |=> pend);
   // R4: clearing cannot drop a level interrupt whose line is high
   p_clr_level_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_mode && line && clr_hit) |=> (pend || edge_mode));
   // R8: acknowledge without competing set drops the latch
   p_ack_clears_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !set_hit && !(edge_mode && line && !lvl_q)) |=> !lat_q);
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank
   import irqp_pkg::*;
#(
   parameter  int NUM_IRQ   = 32,
   parameter  int NUM_SGI   = 16,
   localparam int ID_W      = min1_clog2(NUM_IRQ),
   localparam int CFG_IDX_W = min1_clog2(NUM_IRQ / 4)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_IRQ-1:0]   irq_line,
   input  logic                 cfg_wr_en,
   input  logic [CFG_IDX_W-1:0] cfg_wr_idx,
   input  logic [7:0]           cfg_wr_data,
   input  logic                 set_en,
   input  logic [NUM_IRQ-1:0]   set_mask,
   input  logic                 clr_en,
   input  logic [NUM_IRQ-1:0]   clr_mask,
   input  logic                 ack_en,
   input  logic [ID_W-1:0]      ack_id,
   output logic [NUM_IRQ-1:0]   cfg_edge,
   output logic [NUM_IRQ-1:0]   pending
);
   if (NUM_IRQ % 4 != 0 || NUM_IRQ < 4) begin : g_bad_num
      $error("NUM_IRQ must be a positive multiple of 4");
   end
   if (NUM_SGI > NUM_IRQ || NUM_SGI < 0) begin : g_bad_sgi
      $error("NUM_SGI must lie within 0..NUM_IRQ");
   end

   localparam logic [NUM_IRQ-1:0] SW_OK = {NUM_IRQ{1'b1}} << NUM_SGI;

   logic [NUM_IRQ-1:0] set_hit, clr_hit, ack_hit;

   assign set_hit = {NUM_IRQ{set_en}} & set_mask & SW_OK;
   assign clr_hit = {NUM_IRQ{clr_en}} & clr_mask & SW_OK;

   always_comb begin
      ack_hit = '0;
      if (ack_en) ack_hit[ack_id] = 1'b1;
   end

   irqp_cfg #(
      .NUM_IRQ (NUM_IRQ),
      .NUM_SGI (NUM_SGI),
      .IDX_W   (CFG_IDX_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_idx  (cfg_wr_idx),
      .wr_data (cfg_wr_data),
      .edge_o  (cfg_edge)
   );

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cell
      irqp_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .line      (irq_line[i]),
         .edge_mode (cfg_edge[i]),
         .set_hit   (set_hit[i]),
         .clr_hit   (clr_hit[i]),
         .ack_hit   (ack_hit[i]),
         .pend      (pending[i])
      );
   end

   // R9: set beats clear on the same ID
   p_set_wins_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && clr_en && |(set_mask & clr_mask & SW_OK))
      |=> |(pending & $past(set_mask & clr_mask & SW_OK)));
endmodule

// File: tb/tb_irq_pending_bank.sv
module tb_irq_pending_bank;
   localparam int N = 32;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [N-1:0]  irq_line = '0;
   logic          cfg_wr_en = 0;
   logic [2:0]    cfg_wr_idx = '0;
   logic [7:0]    cfg_wr_data = '0;
   logic          set_en = 0, clr_en = 0, ack_en = 0;
   logic [N-1:0]  set_mask = '0, clr_mask = '0;
   logic [4:0]    ack_id = '0;
   logic [N-1:0]  cfg_edge, pending;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   irq_pending_bank #(.NUM_IRQ(N), .NUM_SGI(16)) dut (
      .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
      .set_en(set_en), .set_mask(set_mask), .clr_en(clr_en), .clr_mask(clr_mask),
      .ack_en(ack_en), .ack_id(ack_id), .cfg_edge(cfg_edge), .pending(pending));

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one clock: inputs applied before it, outputs sampled 1 ns after
   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic strobes_off();
      cfg_wr_en = 0; set_en = 0; clr_en = 0; ack_en = 0;
      set_mask = '0; clr_mask = '0;
   endtask

   task automatic cfg_write(input logic [2:0] idx, input logic [7:0] d);
      cfg_wr_en = 1; cfg_wr_idx = idx; cfg_wr_data = d; step(); strobes_off();
   endtask

   task automatic t_reset();
      check("R10 pending", pending, '0);
      check("R10 modes", cfg_edge, 32'h0000_FFFF);
   endtask

   task automatic t_cfg();
      cfg_write(3'd4, 8'h82);
      check("R6 odd bits", cfg_edge, 32'h0009_FFFF);
      cfg_write(3'd0, 8'h00);
      check("R6 sgi write ignored", cfg_edge, 32'h0009_FFFF);
      cfg_write(3'd4, 8'h01);
      check("R6 even bit ignored", cfg_edge, 32'h0000_FFFF);
      cfg_write(3'd4, 8'h02);
      check("R6 id16 edge", cfg_edge, 32'h0001_FFFF);
   endtask

   task automatic t_level();
      irq_line[20] = 1; step();
      check("R1 level line high", pending, 32'h0010_0000);
      irq_line[20] = 0; step();
      check("R3 level no latch", pending, '0);
   endtask

   task automatic t_edge();
      irq_line[16] = 1; step();
      check("R3 edge rise latches", pending, 32'h0001_0000);
      ack_en = 1; ack_id = 5'd16; step(); strobes_off();
      check("R2 ack with line high", pending, '0);
      step();
      check("R2 held line no repend", pending, '0);
      irq_line[16] = 0; step();
   endtask

   task automatic t_clr_level();
      irq_line[20] = 1; step();
      clr_en = 1; clr_mask = 32'h0010_0000; step(); strobes_off();
      check("R4 clear with line high", pending, 32'h0010_0000);
      irq_line[20] = 0; step();
      check("R4 line falls", pending, '0);
   endtask

   task automatic t_set_level();
      set_en = 1; set_mask = 32'h0010_0000; step(); strobes_off();
      check("R5 sw set", pending, 32'h0010_0000);
      irq_line[20] = 1; step();
      irq_line[20] = 0; step(); step();
      check("R5 stays after line falls", pending, 32'h0010_0000);
      clr_en = 1; clr_mask = 32'h0010_0000; step(); strobes_off();
      check("R5 cleared by sw", pending, '0);
      set_en = 1; set_mask = 32'h0010_0000; step(); strobes_off();
      ack_en = 1; ack_id = 5'd20; step(); strobes_off();
      check("R5 cleared by ack", pending, '0);
   endtask

   task automatic t_sgi();
      set_en = 1; set_mask = '1; step(); strobes_off();
      check("R7 set skips sgi", pending, 32'hFFFF_0000);
      clr_en = 1; clr_mask = '1; step(); strobes_off();
      check("R7 clear all", pending, '0);
      irq_line[3] = 1; step();
      check("R7 sgi line rise", pending, 32'h0000_0008);
      clr_en = 1; clr_mask = '1; step(); strobes_off();
      check("R7 clear skips sgi", pending, 32'h0000_0008);
      ack_en = 1; ack_id = 5'd3; step(); strobes_off();
      check("R8 ack sgi", pending, '0);
      irq_line[3] = 0; step();
   endtask

   task automatic t_ack_rise();
      set_en = 1; set_mask = 32'h0001_0000; step(); strobes_off();
      check("R8 pre-set", pending, 32'h0001_0000);
      ack_en = 1; ack_id = 5'd16; irq_line[16] = 1; step(); strobes_off();
      check("R8 rise beats ack", pending, 32'h0001_0000);
      ack_en = 1; ack_id = 5'd16; step(); strobes_off();
      check("R8 lone ack", pending, '0);
      irq_line[16] = 0; step();
   endtask

   task automatic t_set_clr();
      set_en = 1; set_mask = 32'h0200_0000;
      clr_en = 1; clr_mask = 32'h0200_0000; step(); strobes_off();
      check("R9 set wins", pending, 32'h0200_0000);
      clr_en = 1; clr_mask = 32'h0200_0000; step(); strobes_off();
      check("R9 later clear", pending, '0);
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1; #1;
      t_reset();
      t_cfg();
      t_level();
      t_edge();
      t_clr_level();
      t_set_level();
      t_sgi();
      t_ack_rise();
      t_set_clr();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule